// File: doc/BRIEF.md
# Four-Lane Gradient Word Serializer with Gating Port

This block sits between a gradient waveform sequencer and remote converter boards. Each time the sequencer raises a sample request, the block captures one 24-bit word for each of its four serial lanes and one 12-bit gating word. The upper 8 bits of each 24-bit word are a control field and the lower 16 bits are the data value. The four words leave in lockstep, most significant bit first, on four clock/data pairs. The bit clock is divided down from the system clock by a programmable half-period.

When the last bit has gone out, a load strobe tells every converter to take its new value. On that same system-clock edge the twelve gating outputs switch to the captured gating word, so the serial samples and the gating outputs update as one sample point. Between words, a clear command raises the clear line on all lanes for two bit periods. The serial time of a word limits the sample rate. A request that arrives while a word, a load or a clear is still in progress is dropped and recorded in a sticky overrun flag.

Top module: `grad_serial_out`

## Requirements
- R1: While reset is high and on the first cycle after it, all serial clock, data, load and clear lines are low, the gating outputs are zero and the overrun flag is clear.
- R2: A sample request while the block is idle captures all four words. Lane i takes `word_in[24*i+23 : 24*i]`. From the next cycle each data line presents bit 23, then bits 22 down to 0 in turn. Outside a word's shift phase the data lines are low.
- R3: The half period H equals `half_div`, and a value of 0 is treated as 1. The serial clock is low just after acceptance and rises H system cycles later, with a full period of 2H cycles. Data changes only together with a falling edge of the serial clock.
- R4: All four lanes share one serial clock timing and update their data lines on the same cycles.
- R5: On the falling edge that ends bit 0 (48H cycles after acceptance), the load lines go high for 2H cycles with the serial clock low. The block is then idle and accepts a new request.
- R6: The gating outputs take the gating word captured at acceptance on the same cycle that load rises. At all other times they hold.
- R7: A sample request while the block is shifting, loading or clearing is dropped and has no effect on the lines. It sets an overrun flag that stays set until reset.
- R8: A clear request while the block is idle and no sample request is present drives the clear lines high for 4H cycles. A clear request in any other state has no effect, and when both requests arrive together the sample request wins.
- R9: The half period is captured at acceptance. Changing `half_div` during a word or a clear does not alter its timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| half_div | input | 8 | Serial half period in system cycles (0 acts as 1) |
| sample_req | input | 1 | Start a new sample point |
| word_in | input | 96 | Four 24-bit lane words, lane 0 in the low bits |
| gate_in | input | 12 | Gating word for this sample point |
| clear_req | input | 1 | Request a clear strobe between words |
| ser_clk | output | 4 | Serial clock per lane |
| ser_dat | output | 4 | Serial data per lane, MSB first |
| ser_ld | output | 4 | Load strobe per lane |
| ser_clr | output | 4 | Clear strobe per lane |
| gate_out | output | 12 | Gating outputs |
| overrun | output | 1 | Sticky dropped-request flag |

## Verification
The embedded assertions check on every cycle the properties that hold at all times. Load and clear never overlap, and the serial clock is low during either strobe. Load rises only out of the shift phase, and clear rises only out of idle. The gating outputs change only when load rises, a lane's shift register moves only on a capture or a falling edge, and overrun never falls. The bench's scenarios must show the actual bit order and the exact cycle counts for several half periods, including the divider of zero and a divider changed in mid-word. They must also show the precedence of a sample request over a clear, and that dropped requests and ignored clears leave the lines untouched.

// File: rtl/grad_ser_pkg.sv
package grad_ser_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_LOAD  = 2'd2,
    ST_CLEAR = 2'd3
  } gs_state_t;

  // strobe lengths in serial half periods
  localparam int LOAD_HALVES  = 2;
  localparam int CLEAR_HALVES = 4;
endpackage

// File: rtl/grad_bit_timer.sv
module grad_bit_timer #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             run,
  input  logic [DIV_W-1:0] half_div,
  output logic             tick
);
  logic [DIV_W-1:0] eff;
  logic [DIV_W-1:0] reload_q;
  logic [DIV_W-1:0] cnt_q;

  assign eff  = (half_div == '0) ? DIV_W'(1) : half_div;
  assign tick = run && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      reload_q <= DIV_W'(1);
      cnt_q    <= '0;
    end else if (start) begin
      reload_q <= eff;
      cnt_q    <= eff - DIV_W'(1);
    end else if (run) begin
      if (cnt_q == '0) cnt_q <= reload_q - DIV_W'(1);
      else             cnt_q <= cnt_q - DIV_W'(1);
    end
  end

  // R9: captured half period never changes while running
  p_div_held_r9: assert property (@(posedge clk) disable iff (rst)
    (run && !start) |=> $stable(reload_q));
endmodule

// File: rtl/grad_lane_shift.sv
module grad_lane_shift #(
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_en,
  input  logic              shift_en,
  input  logic [WORD_W-1:0] word,
  output logic              sdata
);
  logic [WORD_W-1:0] sreg_q;

  always_ff @(posedge clk) begin
    if (rst)           sreg_q <= '0;
    else if (load_en)  sreg_q <= word;
    else if (shift_en) sreg_q <= {sreg_q[WORD_W-2:0], 1'b0};
  end

  assign sdata = sreg_q[WORD_W-1];

  // R3: the data line moves only on capture or a falling serial edge
  p_data_moves_r3: assert property (@(posedge clk) disable iff (rst)
    !$stable(sdata) |-> $past(load_en || shift_en));
endmodule

// File: rtl/grad_seq_ctrl.sv
module grad_seq_ctrl
  import grad_ser_pkg::*;
#(
  parameter int WORD_W = 24
) (
  input  logic clk,
  input  logic rst,
  input  logic sample_req,
  input  logic clear_req,
  input  logic tick,
  output logic accept,
  output logic timer_start,
  output logic timer_run,
  output logic shift_en,
  output logic gate_upd,
  output logic sclk,
  output logic load,
  output logic clr,
  output logic overrun
);
  localparam int BW = $clog2(WORD_W);

  gs_state_t      st_q;
  logic [BW-1:0]  bit_q;
  logic [1:0]     ph_q;
  logic           sclk_q, load_q, clr_q, ovr_q;
  logic           idle, clr_go, fall, last_bit;

  assign idle        = (st_q == ST_IDLE);
  assign accept      = idle && sample_req;
  assign clr_go      = idle && clear_req && !sample_req;
  assign timer_start = accept || clr_go;
  assign timer_run   = !idle;
  assign fall        = (st_q == ST_SHIFT) && tick && sclk_q;
  assign last_bit    = (bit_q == BW'(WORD_W - 1));
  assign shift_en    = fall;
  assign gate_upd    = fall && last_bit;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      bit_q  <= '0;
      ph_q   <= '0;
      sclk_q <= 1'b0;
      load_q <= 1'b0;
      clr_q  <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      if (sample_req && !idle) ovr_q <= 1'b1;
      case (st_q)
        ST_IDLE: begin
          if (accept) begin
            st_q   <= ST_SHIFT;
            bit_q  <= '0;
            sclk_q <= 1'b0;
          end else if (clr_go) begin
            st_q  <= ST_CLEAR;
            clr_q <= 1'b1;
            ph_q  <= '0;
          end
        end
        ST_SHIFT: begin
          if (tick) begin
            sclk_q <= ~sclk_q;
            if (sclk_q) begin
              if (last_bit) begin
                st_q   <= ST_LOAD;
                load_q <= 1'b1;
                ph_q   <= '0;
              end else begin
                bit_q <= bit_q + BW'(1);
              end
            end
          end
        end
        ST_LOAD: begin
          if (tick) begin
            if (ph_q == 2'(LOAD_HALVES - 1)) begin
              st_q   <= ST_IDLE;
              load_q <= 1'b0;
            end else begin
              ph_q <= ph_q + 2'd1;
            end
          end
        end
        ST_CLEAR: begin
          if (tick) begin
            if (ph_q == 2'(CLEAR_HALVES - 1)) begin
              st_q  <= ST_IDLE;
              clr_q <= 1'b0;
            end else begin
              ph_q <= ph_q + 2'd1;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign sclk    = sclk_q;
  assign load    = load_q;
  assign clr     = clr_q;
  assign overrun = ovr_q;

  p_load_after_shift_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(load_q) |-> $past(st_q) == ST_SHIFT);
  p_clk_low_strobe_r3: assert property (@(posedge clk) disable iff (rst)
    (load_q || clr_q) |-> !sclk_q);
  p_strobe_excl_r8: assert property (@(posedge clk) disable iff (rst)
    !(load_q && clr_q));
  p_clear_from_idle_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(clr_q) |-> $past(st_q) == ST_IDLE);
  p_ovr_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    $past(ovr_q) |-> ovr_q);
endmodule

// File: rtl/grad_serial_out.sv
module grad_serial_out #(
  parameter int LANES  = 4,
  parameter int CTRL_W = 8,
  parameter int DATA_W = 16,
  parameter int GATE_W = 12,
  parameter int DIV_W  = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [DIV_W-1:0]            half_div,
  input  logic                        sample_req,
  input  logic [LANES*(CTRL_W+DATA_W)-1:0] word_in,
  input  logic [GATE_W-1:0]           gate_in,
  input  logic                        clear_req,
  output logic [LANES-1:0]            ser_clk,
  output logic [LANES-1:0]            ser_dat,
  output logic [LANES-1:0]            ser_ld,
  output logic [LANES-1:0]            ser_clr,
  output logic [GATE_W-1:0]           gate_out,
  output logic                        overrun
);
  localparam int WORD_W = CTRL_W + DATA_W;

  logic              tick, accept, t_start, t_run, shift_en, gate_upd;
  logic              sclk, load, clr;
  logic [GATE_W-1:0] gate_pend_q, gate_q;

  grad_bit_timer #(.DIV_W(DIV_W)) u_timer (
    .clk(clk), .rst(rst), .start(t_start), .run(t_run),
    .half_div(half_div), .tick(tick)
  );

  grad_seq_ctrl #(.WORD_W(WORD_W)) u_ctrl (
    .clk(clk), .rst(rst), .sample_req(sample_req), .clear_req(clear_req),
    .tick(tick), .accept(accept), .timer_start(t_start), .timer_run(t_run),
    .shift_en(shift_en), .gate_upd(gate_upd), .sclk(sclk), .load(load),
    .clr(clr), .overrun(overrun)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    grad_lane_shift #(.WORD_W(WORD_W)) u_lane (
      .clk(clk), .rst(rst), .load_en(accept), .shift_en(shift_en),
      .word(word_in[i*WORD_W +: WORD_W]), .sdata(ser_dat[i])
    );
    assign ser_clk[i] = sclk;
    assign ser_ld[i]  = load;
    assign ser_clr[i] = clr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gate_pend_q <= '0;
      gate_q      <= '0;
    end else begin
      if (accept)   gate_pend_q <= gate_in;
      if (gate_upd) gate_q      <= gate_pend_q;
    end
  end

  assign gate_out = gate_q;

  // R6: gating outputs move only together with the rising load strobe
  p_gate_with_load_r6: assert property (@(posedge clk) disable iff (rst)
    !$stable(gate_q) |-> $rose(load));
endmodule

// File: tb/tb_grad_serial_out.sv
module tb_grad_serial_out;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  half_div = 8'd1;
  logic        sample_req = 1'b0;
  logic [95:0] word_in = '0;
  logic [11:0] gate_in = '0;
  logic        clear_req = 1'b0;
  logic [3:0]  ser_clk, ser_dat, ser_ld, ser_clr;
  logic [11:0] gate_out;
  logic        overrun;

  int vectors = 0;
  int errors  = 0;

  always #4 clk = ~clk;

  grad_serial_out dut (
    .clk(clk), .rst(rst), .half_div(half_div), .sample_req(sample_req),
    .word_in(word_in), .gate_in(gate_in), .clear_req(clear_req),
    .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_ld(ser_ld), .ser_clr(ser_clr),
    .gate_out(gate_out), .overrun(overrun)
  );

  // behavioural reference: 0 idle, 1 shift, 2 load, 3 clear
  int          ms = 0;
  int          mt = 0;
  int          mh = 1;
  logic [23:0] mw [4];
  logic [11:0] mpend = '0;
  logic [11:0] mgate = '0;
  logic        movr = 1'b0;

  always @(posedge clk) begin
    if (rst) begin
      ms = 0; mt = 0; mpend = '0; mgate = '0; movr = 1'b0;
    end else begin
      if (ms != 0 && sample_req) movr = 1'b1;
      case (ms)
        0: begin
          if (sample_req) begin
            for (int i = 0; i < 4; i++) mw[i] = word_in[24*i +: 24];
            mpend = gate_in;
            mh = (half_div == 0) ? 1 : int'(half_div);
            mt = 0; ms = 1;
          end else if (clear_req) begin
            mh = (half_div == 0) ? 1 : int'(half_div);
            mt = 0; ms = 3;
          end
        end
        1: begin
          mt++;
          if (mt == 48*mh) begin ms = 2; mgate = mpend; end
        end
        2: begin
          mt++;
          if (mt == 50*mh) ms = 0;
        end
        default: begin
          mt++;
          if (mt == 4*mh) ms = 0;
        end
      endcase
    end
  end

  task automatic fail(input string req, input string what, input int act, input int exp);
    $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
  endtask

  always @(negedge clk) begin
    logic [3:0]  e_clk, e_dat, e_ld, e_clr;
    logic        bad;
    bad = 1'b0;
    for (int i = 0; i < 4; i++) begin
      e_clk[i] = (ms == 1) ? (((mt / mh) % 2) == 1) : 1'b0;
      e_dat[i] = (ms == 1) ? mw[i][23 - mt/(2*mh)] : 1'b0;
      e_ld[i]  = (ms == 2);
      e_clr[i] = (ms == 3);
    end
    vectors++;
    // R1 applies while reset is high; R4: all lanes share the expected clock
    if (ser_clk !== e_clk) begin bad = 1; fail(rst ? "R1" : "R3 R4", "ser_clk", int'(ser_clk), int'(e_clk)); end
    if (ser_dat !== e_dat) begin bad = 1; fail(rst ? "R1" : "R2", "ser_dat", int'(ser_dat), int'(e_dat)); end
    if (ser_ld !== e_ld)   begin bad = 1; fail(rst ? "R1" : "R5", "ser_ld", int'(ser_ld), int'(e_ld)); end
    if (ser_clr !== e_clr) begin bad = 1; fail(rst ? "R1" : "R8", "ser_clr", int'(ser_clr), int'(e_clr)); end
    if (gate_out !== mgate) begin bad = 1; fail(rst ? "R1" : "R6", "gate_out", int'(gate_out), int'(mgate)); end
    if (overrun !== movr)  begin bad = 1; fail(rst ? "R1" : "R7", "overrun", int'(overrun), int'(movr)); end
    if (bad) errors++;
  end

  task automatic pulse_sample(input logic [95:0] w, input logic [11:0] g);
    word_in = w; gate_in = g; sample_req = 1'b1;
    @(negedge clk);
    sample_req = 1'b0;
  endtask

  task automatic pulse_clear();
    clear_req = 1'b1;
    @(negedge clk);
    clear_req = 1'b0;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;                       // R1 checked during and after reset
    @(negedge clk);
    // R2 R3 R5 R6: fastest divider, distinct lane words
    half_div = 8'd1;
    pulse_sample({24'hA5F00F, 24'h123456, 24'hFFFFFF, 24'h800001}, 12'hA5C);
    repeat (60) @(negedge clk);
    // R7 R8: overrun and ignored clear during a slow word
    half_div = 8'd3;
    pulse_sample({24'h0F0F0F, 24'hC3C3C3, 24'h000000, 24'h7E8181}, 12'h3F1);
    repeat (10) @(negedge clk);
    pulse_sample(96'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF, 12'hFFF);
    repeat (5) @(negedge clk);
    pulse_clear();
    repeat (160) @(negedge clk);
    // R8: clear from idle
    half_div = 8'd2;
    pulse_clear();
    repeat (12) @(negedge clk);
    // R8 priority and R3 divider zero treated as one
    half_div = 8'd0;
    clear_req = 1'b1;
    pulse_sample({24'h5A5A5A, 24'h00FF00, 24'hF0F0F0, 24'h13579B}, 12'h0C3);
    clear_req = 1'b0;
    repeat (60) @(negedge clk);
    // R9: divider changed mid-word is ignored
    half_div = 8'd2;
    pulse_sample({24'h9ABCDE, 24'h2468AC, 24'hE1E1E1, 24'h3C00C3}, 12'h555);
    repeat (20) @(negedge clk);
    half_div = 8'd5;
    repeat (90) @(negedge clk);
    // R5 R7: request held high, back-to-back words with drops
    half_div = 8'd1;
    word_in = {24'h0A0B0C, 24'hD0E0F0, 24'h112233, 24'hCAFE01};
    gate_in = 12'h9E7;
    sample_req = 1'b1;
    repeat (250) @(negedge clk);
    sample_req = 1'b0;
    repeat (60) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=0", vectors);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule